// File: doc/BRIEF.md
# Byte-Wide Serial Master with Flag Handshake

This block is a serial peripheral interface master that sits on a small processor-side register bus. Software writes three registers: configuration, status and data. It selects one of four serial clock rates and any of the four clock polarity and phase combinations. A write to the data register starts a one-byte exchange. The byte goes out on `mosi`, most significant bit first, while `miso` is sampled into a separate receive path. When the byte is finished, the received value is placed in a holding buffer and a completion flag is raised.

The completion flag clears only through a two-step software sequence: first a status read while the flag is set, then any access to the data register. Until the status read happens, writes to the data register are discarded. The select input `ss_n` acts as a fault detector. If it is driven low while master mode is on, the enable and master bits are dropped, any transfer in flight is abandoned, and a sticky fault flag is raised. An interrupt request combines both flags with an enable bit and an external mask.

Top module: `spi_host`

## Requirements
- R1: After reset, `sck` is low, `irq` is low, and the configuration, status and data registers all read as zero.
- R2: Configuration bits [5:4] (code n) set the `sck` period to 4·2^n system clock cycles, so each half period lasts 2·2^n cycles. Between transfers `sck` rests at the level of configuration bit 2 (polarity).
- R3: A byte leaves on `mosi` MSB first and the peer's byte arrives in the same transfer, in all four modes. Configuration bit 3 is the phase bit: 0 samples on the first `sck` edge after idle, 1 samples on the second edge. Each transfer has exactly 16 `sck` edges.
- R4: Status bit 7 (done) rises after the 16th edge. A data register read (address 2) returns the received byte held in the buffer; while the next transfer is running, it still returns the previous byte.
- R5: Done clears only when a status read (address 1) made while done is set is followed by a data register read or write. A data access without that prior status read leaves done set.
- R6: While done is set and no status read has happened since it rose, a data register write is discarded: no `sck` edges, and the flag stays set.
- R7: After the status read, a data register write both clears done and starts a new transfer with the written byte.
- R8: When `ss_n` is low while configuration bit 1 (master) is set, bits 1 and 0 (master, enable) are cleared and status bit 6 (fault) is set. A running transfer is abandoned: `sck` returns to idle and done is not raised.
- R9: Fault clears only when a status read made while it is set is followed by a configuration write (address 0). A configuration write without that prior read leaves it set.
- R10: `irq` is high exactly when configuration bit 6 is set, `irq_mask` is low, and done or fault is set.
- R11: A data register write is discarded while a transfer is running, and also when either configuration bit 0 or bit 1 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (has side effects on the flags) |
| bus_addr | input | 2 | Register select: 0 configuration, 1 status, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, combinational |
| irq_mask | input | 1 | Global interrupt mask, high blocks `irq` |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | input | 1 | Select input, low while master mode is on signals a fault |

## Verification
A corrupted edge counter or half-period counter shows up within one byte time. The peer model sees a gap between `sck` edges that is not the expected length, or sees more or fewer than 16 edges, or gets a shifted byte. A wrong handshake state (a flag armed too early, or a lock that is never released) shows on `irq` in the very next cycle after the bus access that should or should not have cleared the flag. It also shows as `sck` activity, or its absence, right after a data write. A fault path that fails to abort is caught within a few cycles by `sck` sitting off its idle level and by the configuration bits read back.

// File: rtl/spi_host_pkg.sv
// Package: shared constants and the configuration register layout for spi_host.
// Assumes an 8-bit or wider register bus; the configuration fits in its low bits.
package spi_host_pkg;

    localparam int RATE_W = 2;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd2;

    // Configuration register, packed MSB first (bit 6 down to bit 0).
    typedef struct packed {
        logic              irq_en;
        logic [RATE_W-1:0] rate;
        logic              cpha;
        logic              cpol;
        logic              master;
        logic              enable;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/spi_sckgen.sv
// Serial clock generator: while run is high, toggles sck every half period and
// numbers each toggle. When run is low, it holds sck at the polarity level.
// Assumes rate and cpol stay constant while run is high.
module spi_sckgen #(
    parameter int RATE_W    = 2,
    parameter int BASE_LOG2 = 1,
    parameter int EDGES     = 16,
    localparam int HC_W     = BASE_LOG2 + (1 << RATE_W),
    localparam int EC_W     = $clog2(EDGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    input  logic              cpol,
    output logic              sck,
    output logic              edge_p,
    output logic [EC_W-1:0]   edge_idx,
    output logic              last_edge
);

    logic [HC_W-1:0] hc_q;
    logic [HC_W-1:0] half_m1;
    logic [EC_W-1:0] ec_q;
    logic            sck_q;

    // Terminal count of the half-period counter for the selected rate.
    always_comb begin
        half_m1 = (HC_W'(1) << (BASE_LOG2 + int'(rate))) - HC_W'(1);
    end

    assign edge_p    = run && (hc_q == half_m1);
    assign edge_idx  = ec_q;
    assign last_edge = edge_p && (ec_q == EC_W'(EDGES - 1));
    assign sck       = sck_q;

    // Half-period counting, edge numbering and the sck level itself.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hc_q  <= '0;
            ec_q  <= '0;
            sck_q <= 1'b0;
        end else if (!run) begin
            hc_q  <= '0;
            ec_q  <= '0;
            sck_q <= cpol;
        end else if (edge_p) begin
            hc_q  <= '0;
            ec_q  <= ec_q + EC_W'(1);
            sck_q <= ~sck_q;
        end else begin
            hc_q  <= hc_q + HC_W'(1);
        end
    end

endmodule

// File: rtl/spi_shifter.sv
// Byte shifter: separate transmit and receive registers. Which edges sample and
// which edges shift out is chosen by the phase bit. rx_final is the received
// byte including any sample taken on the current edge.
// Assumes load and edge_p are never high in the same cycle.
module spi_shifter #(
    parameter int DATA_W = 8,
    parameter int EC_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              edge_p,
    input  logic [EC_W-1:0]   edge_idx,
    input  logic              cpha,
    input  logic              miso,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_final
);

    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] rx_q;
    logic              sample_now;
    logic              shift_now;

    // Odd/even edge selection by phase; edge 0 never shifts out.
    always_comb begin
        sample_now = edge_p && (edge_idx[0] == cpha);
        shift_now  = edge_p && (edge_idx[0] != cpha) && (edge_idx != '0);
        rx_final   = sample_now ? {rx_q[DATA_W-2:0], miso} : rx_q;
    end

    assign mosi = tx_q[DATA_W-1];

    // Parallel load on start, then shift and sample on the selected edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
            rx_q <= '0;
        end else if (load) begin
            tx_q <= load_data;
            rx_q <= '0;
        end else begin
            if (shift_now)  tx_q <= {tx_q[DATA_W-2:0], 1'b0};
            if (sample_now) rx_q <= rx_final;
        end
    end

endmodule

// File: rtl/spi_regs.sv
// Register file and flag handshake: configuration, done/fault flags with their
// arm bits, the receive buffer, the busy state and the interrupt request.
// Assumes DATA_W >= 8 and that a read strobe and a write strobe never coincide.
module spi_regs
    import spi_host_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ss_n,
    input  logic              irq_mask,
    input  logic              xfer_last,
    input  logic [DATA_W-1:0] rx_final,
    output ctrl_t             ctrl_q,
    output logic              busy,
    output logic              start,
    output logic              done,
    output logic              done_arm,
    output logic              fault,
    output logic              irq
);

    logic              fault_arm;
    logic [DATA_W-1:0] rxbuf_q;
    logic              ctrl_wr, data_wr, data_rd, stat_rd;
    logic              fault_evt, done_clear, fault_clear, abort;
    logic              unused_wbits;

    assign unused_wbits = ^bus_wdata[DATA_W-1:CTRL_W];

    // Bus decode and the handshake conditions.
    always_comb begin
        ctrl_wr     = bus_wr && (bus_addr == ADDR_CTRL);
        data_wr     = bus_wr && (bus_addr == ADDR_DATA);
        data_rd     = bus_rd && (bus_addr == ADDR_DATA);
        stat_rd     = bus_rd && (bus_addr == ADDR_STAT);
        fault_evt   = ctrl_q.master && !ss_n;
        abort       = fault_evt || !ctrl_q.enable || !ctrl_q.master;
        done_clear  = done_arm && (data_wr || data_rd);
        fault_clear = fault_arm && ctrl_wr && !fault_evt;
        start       = data_wr && !busy && !abort && (!done || done_arm);
    end

    // Configuration register; a mode fault drops enable and master.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (ctrl_wr) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (fault_evt) begin
                ctrl_q.master <= 1'b0;
                ctrl_q.enable <= 1'b0;
            end
        end
    end

    // Transfer-in-progress state: set on start, cleared on last edge or abort.
    always_ff @(posedge clk) begin
        if (!rst_n)                      busy <= 1'b0;
        else if (start)                  busy <= 1'b1;
        else if (xfer_last || abort)     busy <= 1'b0;
    end

    // Completion flag, its arm bit, and the receive buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            done_arm <= 1'b0;
            rxbuf_q  <= '0;
        end else if (busy && xfer_last && !abort) begin
            done     <= 1'b1;
            done_arm <= 1'b0;
            rxbuf_q  <= rx_final;
        end else if (done_clear) begin
            done     <= 1'b0;
            done_arm <= 1'b0;
        end else if (stat_rd && done) begin
            done_arm <= 1'b1;
        end
    end

    // Mode-fault flag and its arm bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault     <= 1'b0;
            fault_arm <= 1'b0;
        end else if (fault_evt) begin
            fault     <= 1'b1;
        end else if (fault_clear) begin
            fault     <= 1'b0;
            fault_arm <= 1'b0;
        end else if (stat_rd && fault) begin
            fault_arm <= 1'b1;
        end
    end

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_CTRL: bus_rdata[CTRL_W-1:0] = ctrl_q;
            ADDR_STAT: begin
                bus_rdata[DATA_W-1] = done;
                bus_rdata[DATA_W-2] = fault;
            end
            ADDR_DATA: bus_rdata = rxbuf_q;
            default:   bus_rdata = '0;
        endcase
    end

    assign irq = ctrl_q.irq_en && !irq_mask && (done || fault);

endmodule

// File: rtl/spi_host.sv
// Top: register-mapped serial master. Connects the register/handshake block,
// the serial clock generator and the byte shifter.
// Assumes software leaves the configuration alone while a byte is in flight.
module spi_host
    import spi_host_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int BASE_LOG2 = 1,
    localparam int EDGES    = 2 * DATA_W,
    localparam int EC_W     = $clog2(EDGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              irq_mask,
    output logic              irq,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    input  logic              ss_n
);

    ctrl_t             ctrl_q;
    logic              busy, start, done, done_arm, fault;
    logic              edge_p, last_edge;
    logic [EC_W-1:0]   edge_idx;
    logic [DATA_W-1:0] rx_final;

    spi_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ss_n      (ss_n),
        .irq_mask  (irq_mask),
        .xfer_last (last_edge),
        .rx_final  (rx_final),
        .ctrl_q    (ctrl_q),
        .busy      (busy),
        .start     (start),
        .done      (done),
        .done_arm  (done_arm),
        .fault     (fault),
        .irq       (irq)
    );

    spi_sckgen #(.RATE_W(RATE_W), .BASE_LOG2(BASE_LOG2), .EDGES(EDGES)) u_sckgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .rate      (ctrl_q.rate),
        .cpol      (ctrl_q.cpol),
        .sck       (sck),
        .edge_p    (edge_p),
        .edge_idx  (edge_idx),
        .last_edge (last_edge)
    );

    spi_shifter #(.DATA_W(DATA_W), .EC_W(EC_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .load_data (bus_wdata),
        .edge_p    (edge_p),
        .edge_idx  (edge_idx),
        .cpha      (ctrl_q.cpha),
        .miso      (miso),
        .mosi      (mosi),
        .rx_final  (rx_final)
    );

endmodule

// File: rtl/spi_host_chk.sv
// Checker: temporal properties of spi_host, attached by bind below.
// Assumes it sees the top's flag, busy and configuration state.
module spi_host_chk
    import spi_host_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sck,
    input logic              ss_n,
    input logic              irq,
    input logic              irq_mask,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input ctrl_t             ctrl_q,
    input logic              busy,
    input logic              done,
    input logic              done_arm,
    input logic              fault
);

    p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy) && $stable(ctrl_q.cpol)) |-> (sck == ctrl_q.cpol));

    p_done_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(busy) && !busy));

    p_done_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done) |-> $past((bus_wr || bus_rd) && bus_addr == ADDR_DATA));

    p_write_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_arm && bus_wr && bus_addr == ADDR_DATA) |=> !busy);

    p_mode_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ss_n && ctrl_q.master) |=> (fault && !ctrl_q.master && !ctrl_q.enable && !busy));

    p_fault_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault) |-> $past(bus_wr && bus_addr == ADDR_CTRL));

    p_irq_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask |-> !irq);

    p_start_cond_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_wr && bus_addr == ADDR_DATA && ctrl_q.enable && ctrl_q.master));

endmodule

bind spi_host spi_host_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck      (sck),
    .ss_n     (ss_n),
    .irq      (irq),
    .irq_mask (irq_mask),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .ctrl_q   (ctrl_q),
    .busy     (busy),
    .done     (done),
    .done_arm (done_arm),
    .fault    (fault)
);

// File: tb/tb_spi_host.sv
`timescale 1ns/1ps
// Directed bench for spi_host with a behavioural serial peer.
module tb_spi_host;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq_mask = 1'b0;
    logic       irq;
    logic       sck;
    logic       mosi;
    logic       miso;
    logic       ss_n = 1'b1;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    spi_host dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_mask(irq_mask), .irq(irq), .sck(sck), .mosi(mosi),
        .miso(miso), .ss_n(ss_n)
    );

    // Peer model: owns miso; counts sck edges, samples mosi and measures gaps.
    int         arm_seq = 0;
    logic [7:0] peer_byte = 8'h00;
    logic       peer_cpha = 1'b0;
    int         seen_seq = 0;
    int         p_edges = 0;
    logic [7:0] p_tx = 8'h00;
    logic [7:0] p_rx = 8'h00;
    logic       p_prev = 1'b0;
    int         p_cyc = 0;
    int         p_last = 0;
    int         gap_min = 0;
    int         gap_max = 0;

    initial miso = 1'b0;

    always @(negedge clk) begin
        p_cyc = p_cyc + 1;
        if (arm_seq != seen_seq) begin
            seen_seq = arm_seq;
            p_edges  = 0;
            p_tx     = peer_byte;
            miso     = peer_byte[7];
            p_rx     = 8'h00;
            p_prev   = sck;
            gap_min  = 100000;
            gap_max  = 0;
            p_last   = p_cyc;
        end else if (sck !== p_prev) begin
            p_prev = sck;
            if (p_edges > 0) begin
                if (p_cyc - p_last < gap_min) gap_min = p_cyc - p_last;
                if (p_cyc - p_last > gap_max) gap_max = p_cyc - p_last;
            end
            p_last = p_cyc;
            if (p_edges[0] == peer_cpha) begin
                p_rx = {p_rx[6:0], mosi};
            end else begin
                if (p_edges != 0) p_tx = {p_tx[6:0], 1'b0};
                miso = p_tx[7];
            end
            p_edges = p_edges + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            failures = failures + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic logic [7:0] cfg(input logic ie, input logic [1:0] rate,
                                       input logic cpha, input logic cpol);
        return {1'b0, ie, rate, cpha, cpol, 1'b1, 1'b1};
    endfunction

    task automatic peer_arm(input logic [7:0] b, input logic cpha);
        peer_byte = b;
        peer_cpha = cpha;
        arm_seq   = arm_seq + 1;
        @(negedge clk);
    endtask

    task automatic wait_edges(input int n);
        for (int i = 0; i < 5000 && p_edges < n; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Full exchange in one mode and rate; checks clock, data and handshake.
    task automatic t_exchange(input logic cpol, input logic cpha, input logic [1:0] rate,
                              input logic [7:0] tx, input logic [7:0] rx);
        logic [7:0] v;
        bus_write(2'd0, cfg(1'b0, rate, cpha, cpol));
        repeat (2) @(negedge clk);
        chk("R2 idle level", {31'd0, sck}, {31'd0, cpol});
        peer_arm(rx, cpha);
        bus_write(2'd2, tx);
        wait_edges(16);
        chk("R3 edge count", p_edges, 16);
        chk("R3 peer got byte", {24'd0, p_rx}, {24'd0, tx});
        chk("R2 half period min", gap_min, 2 << rate);
        chk("R2 half period max", gap_max, 2 << rate);
        chk("R2 idle after", {31'd0, sck}, {31'd0, cpol});
        bus_read(2'd1, v);
        chk("R4 done set", {24'd0, v}, 32'h80);
        bus_read(2'd2, v);
        chk("R4 rx buffer", {24'd0, v}, {24'd0, rx});
        bus_read(2'd1, v);
        chk("R5 done cleared", {24'd0, v}, 32'h00);
    endtask

    // Reset state of all registers and outputs.
    task automatic t_reset();
        logic [7:0] v;
        chk("R1 sck", {31'd0, sck}, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        bus_read(2'd0, v); chk("R1 ctrl", {24'd0, v}, 0);
        bus_read(2'd1, v); chk("R1 status", {24'd0, v}, 0);
        bus_read(2'd2, v); chk("R1 data", {24'd0, v}, 0);
    endtask

    // Write lock while done is pending, clear sequence, buffer during transfer.
    task automatic t_handshake();
        logic [7:0] v;
        bus_write(2'd0, cfg(1'b1, 2'd0, 1'b0, 1'b0));
        repeat (2) @(negedge clk);
        peer_arm(8'h5A, 1'b0);
        bus_write(2'd2, 8'hC3);
        wait_edges(16);
        chk("R10 irq on done", {31'd0, irq}, 1);
        irq_mask = 1'b1;
        #1 chk("R10 mask blocks", {31'd0, irq}, 0);
        irq_mask = 1'b0;
        peer_arm(8'h99, 1'b0);
        bus_write(2'd2, 8'h55);
        repeat (60) @(negedge clk);
        chk("R6 locked write no sck", p_edges, 0);
        chk("R6 done still set", {31'd0, irq}, 1);
        bus_read(2'd2, v);
        chk("R4 buffered byte", {24'd0, v}, 32'h5A);
        chk("R5 data read alone keeps done", {31'd0, irq}, 1);
        bus_read(2'd1, v);
        chk("R5 status shows done", {24'd0, v}, 32'h80);
        bus_write(2'd2, 8'h66);
        chk("R7 write clears done", {31'd0, irq}, 0);
        wait_edges(8);
        bus_read(2'd2, v);
        chk("R4 old byte mid transfer", {24'd0, v}, 32'h5A);
        wait_edges(16);
        chk("R7 new byte sent", {24'd0, p_rx}, 32'h66);
        bus_read(2'd1, v);
        bus_read(2'd2, v);
        chk("R7 new byte received", {24'd0, v}, 32'h99);
        chk("R10 irq low after clear", {31'd0, irq}, 0);
    endtask

    // Writes ignored while busy and while not enabled.
    task automatic t_ignored_writes();
        logic [7:0] v;
        bus_write(2'd0, cfg(1'b0, 2'd2, 1'b1, 1'b0));
        repeat (2) @(negedge clk);
        peer_arm(8'h11, 1'b1);
        bus_write(2'd2, 8'h3C);
        repeat (20) @(negedge clk);
        bus_write(2'd2, 8'hFF);
        wait_edges(16);
        chk("R11 busy write ignored", {24'd0, p_rx}, 32'h3C);
        chk("R11 edge count", p_edges, 16);
        bus_read(2'd1, v);
        bus_read(2'd2, v);
        bus_write(2'd0, 8'h02);
        repeat (2) @(negedge clk);
        peer_arm(8'h00, 1'b0);
        bus_write(2'd2, 8'hAA);
        repeat (50) @(negedge clk);
        chk("R11 disabled write ignored", p_edges, 0);
    endtask

    // Mode fault abort and its clear sequence.
    task automatic t_fault();
        logic [7:0] v;
        bus_write(2'd0, cfg(1'b1, 2'd3, 1'b0, 1'b1));
        repeat (2) @(negedge clk);
        peer_arm(8'h42, 1'b0);
        bus_write(2'd2, 8'h81);
        repeat (40) @(negedge clk);
        ss_n = 1'b0;
        @(negedge clk);
        ss_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 sck idle after abort", {31'd0, sck}, 1);
        bus_read(2'd0, v);
        chk("R8 master and enable cleared", {24'd0, v}, {24'd0, cfg(1'b1, 2'd3, 1'b0, 1'b1) & 8'hFC});
        chk("R10 irq on fault", {31'd0, irq}, 1);
        repeat (300) @(negedge clk);
        chk("R8 no further edges", {31'd0, p_edges < 16}, 1);
        bus_write(2'd0, cfg(1'b1, 2'd3, 1'b0, 1'b1));
        chk("R9 ctrl write alone keeps fault", {31'd0, irq}, 1);
        bus_read(2'd1, v);
        chk("R8 status fault no done", {24'd0, v}, 32'h40);
        bus_write(2'd0, cfg(1'b1, 2'd0, 1'b0, 1'b0));
        bus_read(2'd1, v);
        chk("R9 fault cleared", {24'd0, v}, 32'h00);
        chk("R9 irq low", {31'd0, irq}, 0);
        bus_write(2'd0, 8'h00);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_exchange(1'b0, 1'b0, 2'd0, 8'hA5, 8'h3C);
        t_exchange(1'b0, 1'b1, 2'd1, 8'h80, 8'h01);
        t_exchange(1'b1, 1'b0, 2'd2, 8'h4E, 8'hB7);
        t_exchange(1'b1, 1'b1, 2'd3, 8'h01, 8'hFE);
        t_handshake();
        t_ignored_writes();
        t_fault();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
        $finish;
    end

endmodule